// File: doc/BRIEF.md
# Clock Frequency Classifier

The block measures a recovered clock of unknown frequency against a reference clock whose frequency is known. It counts the recovered clock's rising edges over a fixed window of reference cycles. The count is exposed as a ratio value. The block also turns the count into a 3-bit code that names the nearest of eight standard audio clock frequencies.

The decision thresholds depend on which of three reference frequencies the select input names. A force control pins the code to all ones. The code, an active-clock-source flag and four zero bits are packed into a status byte in the reference domain. A one-cycle valid strobe marks each new result. If the reference is not one of the three supported frequencies, a host can still work out the recovered frequency from the ratio value.

The count is made in the recovered-clock domain and returned through a toggle handshake. A timeout in the reference domain reports a count of zero when the recovered clock has stopped.

Top module: `clk_freq_classifier`

## Requirements
- R1: While reset is low, and after reset until the first result, `status` is 8'h00, `ratio` is 0 and `valid` is 0.
- R2: `valid` is high for exactly one reference cycle per completed window. Successive pulses are at least GATE reference cycles apart.
- R3: On a `valid` pulse, `ratio` holds the number of recovered-clock rising edges counted during a gate of GATE reference cycles. This is GATE × f_meas / f_ref, within ±2.
- R4: On a `valid` pulse, `status[2:0]` gives the nearest nominal frequency: 000 = 8.192 MHz, 001 = 11.2896, 010 = 12.288, 011 = 16.384, 100 = 22.5792, 101 = 24.576, 110 = 45.1584, 111 = 49.152 MHz.
- R5: `ref_sel` names the reference frequency used by the thresholds: 00 = 12.288 MHz, 01 = 18.432 MHz, 10 and 11 = 24.576 MHz.
- R6: A recovered frequency that matches none of the eight values gives the code of the closest one. The boundaries are the midpoints between adjacent nominal counts.
- R7: One reference cycle after `force_lock` is sampled high, `status[2:0]` reads 111 for as long as it stays high. After it drops, the field again shows the last measured code.
- R8: `status[7:4]` always reads 0. `status[3]` shows `active_src` one reference cycle after it is sampled (0 = PLL output, 1 = reference clock).
- R9: Between `valid` pulses, `ratio` and the measured code hold their values.
- R10: If the recovered clock stops, each window ends after a wait of WAIT_LIM reference cycles. It then reports `ratio` = 0 and code 000.
- R11: A count above the top midpoint gives code 111. The edge counter saturates at its all-ones value rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock of known frequency |
| meas_clk | input | 1 | Recovered clock being measured |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| ref_sel | input | 2 | Reference frequency select (see R5) |
| force_lock | input | 1 | Forces the code field to 111 |
| active_src | input | 1 | Active system clock source flag, shown in status bit 3 |
| status | output | 8 | {4'b0, active source, frequency code} |
| ratio | output | CNT_W | Recovered-clock edges per gate window |
| valid | output | 1 | One-cycle strobe marking a new result |

## Verification
A new `ratio` and code appear one reference cycle after the window's result is captured. Capture follows the GATE-cycle gate, a few recovered-clock cycles of handshake and a two-flop synchroniser, or the WAIT_LIM timeout. The exact cycle therefore varies with the clock ratio, so the scoreboard compares values on the falling edge where `valid` is high. Any window that was under way when a setting changed is discarded before an expected item is queued. The force and active-source effects are due one reference edge after the input is sampled, and the bench checks them on the second falling edge after driving them.

// File: rtl/clkclass_pkg.sv
`timescale 1ns/1ps
package clkclass_pkg;

  typedef enum logic {ST_GATE = 1'b0, ST_WAIT = 1'b1} win_state_e;

  localparam int unsigned NUM_CODES = 8;
  localparam int unsigned NUM_MIDS  = NUM_CODES - 1;

  // nominal measured frequency, units of 100 Hz
  function automatic longint unsigned nom_freq(int unsigned code);
    case (code)
      0:       return 64'd81920;
      1:       return 64'd112896;
      2:       return 64'd122880;
      3:       return 64'd163840;
      4:       return 64'd225792;
      5:       return 64'd245760;
      6:       return 64'd451584;
      default: return 64'd491520;
    endcase
  endfunction

  // reference frequency per select value, units of 100 Hz
  function automatic longint unsigned ref_freq(int unsigned sel);
    case (sel)
      0:       return 64'd122880;
      1:       return 64'd184320;
      default: return 64'd245760;
    endcase
  endfunction

  // midpoint count between code k and k+1 for a gate of 'gate' ref cycles
  function automatic longint unsigned mid_count(int unsigned k, int unsigned sel,
                                                longint unsigned gate, int unsigned cnt_w);
    longint unsigned num;
    longint unsigned lim;
    num = gate * (nom_freq(k) + nom_freq(k + 1));
    lim = (64'd1 << cnt_w) - 64'd1;
    if ((num / (64'd2 * ref_freq(sel))) > lim) return lim;
    return num / (64'd2 * ref_freq(sel));
  endfunction

endpackage

// File: rtl/clkclass_sync2.sv
`timescale 1ns/1ps
module clkclass_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/clkclass_meas_counter.sv
`timescale 1ns/1ps
module clkclass_meas_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             meas_clk,
  input  logic             rst_n,
  input  logic             gate_ref,
  output logic [CNT_W-1:0] hold_cnt,
  output logic             done_tgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_m;
  logic             gate_d;
  logic             gate_rise;
  logic             gate_fall;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hold_q;
  logic             tgl_q;

  clkclass_sync2 #(.RST_VAL(1'b0)) u_gate_sync (
    .clk  (meas_clk),
    .rst_n(rst_n),
    .d    (gate_ref),
    .q    (gate_m)
  );

  assign gate_rise = gate_m & ~gate_d;
  assign gate_fall = ~gate_m & gate_d;

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      gate_d <= gate_m;
      if (gate_rise) begin
        cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
      end else if (gate_m && (cnt_q != CNT_MAX)) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (gate_fall) begin
        hold_q <= cnt_q;
        tgl_q  <= ~tgl_q;
      end
    end
  end

  assign hold_cnt = hold_q;
  assign done_tgl = tgl_q;
endmodule

// File: rtl/clkclass_gate_ctrl.sv
`timescale 1ns/1ps
module clkclass_gate_ctrl
  import clkclass_pkg::*;
#(
  parameter int unsigned GATE     = 4096,
  parameter int unsigned WAIT_LIM = 64,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] hold_cnt,
  input  logic             done_tgl,
  output logic             gate_out,
  output logic             res_stb,
  output logic [CNT_W-1:0] res_cnt,
  output logic             tmo_evt
);
  localparam int unsigned LIM   = (GATE > WAIT_LIM) ? GATE : WAIT_LIM;
  localparam int unsigned WIN_W = $clog2(LIM + 1);
  localparam logic [WIN_W-1:0] GATE_END = WIN_W'(GATE - 1);
  localparam logic [WIN_W-1:0] WAIT_END = WIN_W'(WAIT_LIM - 1);

  win_state_e       state_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic             gate_q;
  logic             done_s;
  logic             seen_q;
  logic             stb_q;
  logic             tmo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             got_result;
  logic             wait_expired;

  clkclass_sync2 #(.RST_VAL(1'b0)) u_done_sync (
    .clk  (ref_clk),
    .rst_n(rst_n),
    .d    (done_tgl),
    .q    (done_s)
  );

  assign got_result   = (state_q == ST_WAIT) && (done_s != seen_q);
  assign wait_expired = (state_q == ST_WAIT) && !got_result && (win_cnt_q == WAIT_END);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_GATE;
      win_cnt_q <= '0;
      gate_q    <= 1'b1;
      seen_q    <= 1'b0;
      stb_q     <= 1'b0;
      tmo_q     <= 1'b0;
      cnt_q     <= '0;
    end else begin
      stb_q <= 1'b0;
      tmo_q <= 1'b0;
      case (state_q)
        ST_GATE: begin
          seen_q <= done_s;
          if (win_cnt_q == GATE_END) begin
            state_q   <= ST_WAIT;
            win_cnt_q <= '0;
            gate_q    <= 1'b0;
          end else begin
            win_cnt_q <= win_cnt_q + 1'b1;
          end
        end
        default: begin
          if (got_result) begin
            seen_q    <= done_s;
            cnt_q     <= hold_cnt;
            stb_q     <= 1'b1;
            state_q   <= ST_GATE;
            win_cnt_q <= '0;
            gate_q    <= 1'b1;
          end else if (wait_expired) begin
            cnt_q     <= '0;
            stb_q     <= 1'b1;
            tmo_q     <= 1'b1;
            state_q   <= ST_GATE;
            win_cnt_q <= '0;
            gate_q    <= 1'b1;
          end else begin
            win_cnt_q <= win_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_out = gate_q;
  assign res_stb  = stb_q;
  assign res_cnt  = cnt_q;
  assign tmo_evt  = tmo_q;
endmodule

// File: rtl/clkclass_decide.sv
`timescale 1ns/1ps
module clkclass_decide
  import clkclass_pkg::*;
#(
  parameter int unsigned GATE  = 4096,
  parameter int unsigned CNT_W = 16
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [1:0]       ref_sel,
  input  logic             force_lock,
  input  logic             active_src,
  input  logic             res_stb,
  input  logic [CNT_W-1:0] res_cnt,
  output logic [7:0]       status,
  output logic [CNT_W-1:0] ratio,
  output logic             valid,
  output logic             force_q
);
  localparam int unsigned NUM_SEL = 4;

  logic [CNT_W-1:0] thr_tab [NUM_SEL][NUM_MIDS];
  logic [NUM_MIDS-1:0] above;
  logic [2:0]       code_n;
  logic [2:0]       code_q;
  logic [CNT_W-1:0] ratio_q;
  logic             valid_q;
  logic             force_r;
  logic             act_r;

  // midpoint thresholds, one constant per select value and boundary
  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    for (genvar k = 0; k < NUM_MIDS; k++) begin : g_mid
      localparam longint unsigned THR = mid_count(k, s, GATE, CNT_W);
      assign thr_tab[s][k] = CNT_W'(THR);
    end
  end

  for (genvar k = 0; k < NUM_MIDS; k++) begin : g_cmp
    assign above[k] = res_cnt > thr_tab[ref_sel][k];
  end

  assign code_n = 3'($countones(above));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      ratio_q <= '0;
      valid_q <= 1'b0;
      force_r <= 1'b0;
      act_r   <= 1'b0;
    end else begin
      valid_q <= res_stb;
      force_r <= force_lock;
      act_r   <= active_src;
      if (res_stb) begin
        code_q  <= code_n;
        ratio_q <= res_cnt;
      end
    end
  end

  assign status  = {4'b0000, act_r, force_r ? 3'b111 : code_q};
  assign ratio   = ratio_q;
  assign valid   = valid_q;
  assign force_q = force_r;
endmodule

// File: rtl/clk_freq_classifier.sv
`timescale 1ns/1ps
module clk_freq_classifier #(
  parameter int unsigned GATE     = 4096,
  parameter int unsigned WAIT_LIM = 64,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             ref_clk,
  input  logic             meas_clk,
  input  logic             rst_n,
  input  logic [1:0]       ref_sel,
  input  logic             force_lock,
  input  logic             active_src,
  output logic [7:0]       status,
  output logic [CNT_W-1:0] ratio,
  output logic             valid
);
  logic             gate_ref;
  logic [CNT_W-1:0] hold_cnt;
  logic             done_tgl;
  logic             res_stb;
  logic [CNT_W-1:0] res_cnt;
  logic             tmo_evt;
  logic             force_q;

  clkclass_meas_counter #(.CNT_W(CNT_W)) u_meas (
    .meas_clk(meas_clk),
    .rst_n   (rst_n),
    .gate_ref(gate_ref),
    .hold_cnt(hold_cnt),
    .done_tgl(done_tgl)
  );

  clkclass_gate_ctrl #(.GATE(GATE), .WAIT_LIM(WAIT_LIM), .CNT_W(CNT_W)) u_gate (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .hold_cnt(hold_cnt),
    .done_tgl(done_tgl),
    .gate_out(gate_ref),
    .res_stb (res_stb),
    .res_cnt (res_cnt),
    .tmo_evt (tmo_evt)
  );

  clkclass_decide #(.GATE(GATE), .CNT_W(CNT_W)) u_decide (
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .ref_sel   (ref_sel),
    .force_lock(force_lock),
    .active_src(active_src),
    .res_stb   (res_stb),
    .res_cnt   (res_cnt),
    .status    (status),
    .ratio     (ratio),
    .valid     (valid),
    .force_q   (force_q)
  );
endmodule

// File: rtl/clk_freq_classifier_chk.sv
`timescale 1ns/1ps
module clk_freq_classifier_chk #(
  parameter int unsigned GATE  = 4096,
  parameter int unsigned CNT_W = 16
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic [7:0]       status,
  input logic [CNT_W-1:0] ratio,
  input logic             valid,
  input logic             force_q,
  input logic             res_stb,
  input logic             tmo_evt
);
  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (valid) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 1;
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    valid |=> !valid);

  // R2
  valid_follows_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    res_stb |=> valid);

  // R2
  valid_gap_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (valid && seen_q) |-> (gap_q >= GATE));

  // R9
  ratio_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !valid |-> $stable(ratio));

  // R9
  code_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!valid && !force_q && !$past(force_q)) |-> $stable(status[2:0]));

  // R7
  force_code_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    force_q |-> (status[2:0] == 3'b111));

  // R8
  reserved_zero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    status[7:4] == 4'b0000);

  // R10
  timeout_zero_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    tmo_evt |=> (ratio == '0));

  // R10
  zero_count_code_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (valid && (ratio == '0) && !force_q) |-> (status[2:0] == 3'b000));
endmodule

bind clk_freq_classifier clk_freq_classifier_chk #(.GATE(GATE), .CNT_W(CNT_W)) u_chk (
  .ref_clk(ref_clk),
  .rst_n  (rst_n),
  .status (status),
  .ratio  (ratio),
  .valid  (valid),
  .force_q(force_q),
  .res_stb(res_stb),
  .tmo_evt(tmo_evt)
);

// File: tb/clk_freq_classifier_test.sv
`timescale 1ns/1ps
module clk_freq_classifier_test;
  localparam real         CLK_PERIOD = 10.0;
  localparam int unsigned TB_GATE    = 1024;
  localparam int unsigned TB_WAIT    = 64;
  localparam int unsigned TB_CNT_W   = 16;

  typedef struct {
    real        ratio_exp;
    logic [2:0] code_exp;
    logic       act_exp;
    int         req;
  } item_t;

  logic                ref_clk = 1'b0;
  logic                meas_clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [1:0]          ref_sel = 2'b00;
  logic                force_lock = 1'b0;
  logic                active_src = 1'b0;
  logic [7:0]          status;
  logic [TB_CNT_W-1:0] ratio;
  logic                valid;

  realtime meas_half = 5.0;
  bit      meas_run = 1'b1;
  int      checks = 0;
  int      errors = 0;
  bit      finished = 1'b0;
  item_t   sb_q[$];
  real     cur_ratio;
  logic [2:0] cur_code;

  clk_freq_classifier #(.GATE(TB_GATE), .WAIT_LIM(TB_WAIT), .CNT_W(TB_CNT_W)) uut (
    .ref_clk   (ref_clk),
    .meas_clk  (meas_clk),
    .rst_n     (rst_n),
    .ref_sel   (ref_sel),
    .force_lock(force_lock),
    .active_src(active_src),
    .status    (status),
    .ratio     (ratio),
    .valid     (valid)
  );

  always #(CLK_PERIOD / 2.0) ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (meas_run) #(meas_half) meas_clk = ~meas_clk;
      else #1;
    end
  end

  function automatic real ref_mhz(logic [1:0] sel);
    if (sel == 2'b00) return 12.288;
    if (sel == 2'b01) return 18.432;
    return 24.576;
  endfunction

  function automatic real table_mhz(int k);
    real t [8] = '{8.192, 11.2896, 12.288, 16.384, 22.5792, 24.576, 45.1584, 49.152};
    return t[k];
  endfunction

  // nearest nominal frequency by absolute distance
  function automatic logic [2:0] nearest(real f);
    real best_d = 1.0e9;
    logic [2:0] best = 3'd0;
    for (int k = 0; k < 8; k++) begin
      real d = (f > table_mhz(k)) ? f - table_mhz(k) : table_mhz(k) - f;
      if (d < best_d) begin
        best_d = d;
        best = 3'(k);
      end
    end
    return best;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic wait_valid();
    do @(negedge ref_clk); while (!valid);
  endtask

  // set the recovered clock to f_meas while the reference stands for f_ref
  task automatic set_meas(real f_meas);
    real per;
    real half_ps;
    per = CLK_PERIOD * ref_mhz(ref_sel) / f_meas;
    half_ps = $floor(per * 500.0 + 0.5);
    meas_half = half_ps / 1000.0;
    cur_ratio = TB_GATE * CLK_PERIOD / (2.0 * meas_half);
    cur_code = nearest(ref_mhz(ref_sel) * CLK_PERIOD / (2.0 * meas_half));
  endtask

  task automatic run_item(logic [1:0] sel, real f_meas, int req);
    item_t it;
    ref_sel = sel;
    set_meas(f_meas);
    wait_valid();
    wait_valid();
    @(negedge ref_clk);
    it.ratio_exp = cur_ratio;
    it.code_exp = cur_code;
    it.act_exp = active_src;
    it.req = req;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(negedge ref_clk);
  endtask

  // monitor: compare each result as it is produced
  always @(negedge ref_clk) begin
    if (rst_n && valid && sb_q.size() != 0) begin
      item_t it;
      real diff;
      it = sb_q.pop_front();
      diff = real'(ratio) - it.ratio_exp;
      if (diff < 0.0) diff = -diff;
      // R3 ratio against GATE * f_meas / f_ref
      check(diff <= 2.0, $sformatf("R3/R%0d", it.req), "ratio", longint'(ratio),
            longint'($rtoi(it.ratio_exp)));
      // R4 code against the nearest nominal frequency
      check(status[2:0] == it.code_exp, $sformatf("R4/R%0d", it.req), "code",
            longint'(status[2:0]), longint'(it.code_exp));
      check(status[3] == it.act_exp, "R8", "active bit", longint'(status[3]),
            longint'(it.act_exp));
    end
  end

  initial begin
    repeat (180000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    finish_run();
  end

  initial begin
    int cyc;
    logic [TB_CNT_W-1:0] held;
    logic [2:0] last_code;
    set_meas(12.288);
    repeat (3) @(negedge ref_clk);
    // R1 reset state
    check(status == 8'h00, "R1", "status in reset", longint'(status), 0);
    check(ratio == '0, "R1", "ratio in reset", longint'(ratio), 0);
    check(valid == 1'b0, "R1", "valid in reset", longint'(valid), 0);
    rst_n = 1'b1;
    cyc = 0;
    @(negedge ref_clk);
    check(status == 8'h00 && ratio == '0, "R1", "state after reset", longint'(status), 0);
    do begin
      @(negedge ref_clk);
      cyc++;
    end while (!valid);
    // R2 first window lasts at least a gate
    check(cyc >= TB_GATE, "R2", "cycles to first valid", cyc, TB_GATE);
    @(negedge ref_clk);
    check(valid == 1'b0, "R2", "valid pulse width", longint'(valid), 0);

    // R4 table values at 12.288 MHz reference
    run_item(2'b00, 8.192, 4);
    run_item(2'b00, 11.2896, 4);
    run_item(2'b00, 16.384, 4);
    run_item(2'b00, 22.5792, 4);
    run_item(2'b00, 45.1584, 4);
    run_item(2'b00, 49.152, 4);
    // R5 other reference selects
    run_item(2'b01, 24.576, 5);
    run_item(2'b01, 12.288, 5);
    run_item(2'b10, 8.192, 5);
    run_item(2'b11, 12.288, 5);
    // R6 off-table frequencies
    run_item(2'b00, 14.0, 6);
    run_item(2'b00, 30.0, 6);
    // R11 above the top midpoint
    run_item(2'b00, 60.0, 11);

    // R9 hold between pulses
    held = ratio;
    last_code = status[2:0];
    repeat (100) @(negedge ref_clk);
    check(ratio == held, "R9", "ratio hold", longint'(ratio), longint'(held));
    check(status[2:0] == last_code, "R9", "code hold", longint'(status[2:0]),
          longint'(last_code));

    // R7 force override and release
    force_lock = 1'b1;
    repeat (2) @(negedge ref_clk);
    check(status[2:0] == 3'b111, "R7", "forced code", longint'(status[2:0]), 7);
    force_lock = 1'b0;
    run_item(2'b00, 12.288, 4);
    force_lock = 1'b1;
    repeat (2) @(negedge ref_clk);
    check(status[2:0] == 3'b111, "R7", "forced code over 010", longint'(status[2:0]), 7);
    force_lock = 1'b0;
    repeat (2) @(negedge ref_clk);
    check(status[2:0] == 3'b010, "R7", "code after release", longint'(status[2:0]), 2);

    // R8 active source bit and reserved bits
    active_src = 1'b1;
    repeat (2) @(negedge ref_clk);
    check(status[3] == 1'b1, "R8", "active bit set", longint'(status[3]), 1);
    check(status[7:4] == 4'b0000, "R8", "reserved bits", longint'(status[7:4]), 0);
    run_item(2'b10, 24.576, 8);
    active_src = 1'b0;
    repeat (2) @(negedge ref_clk);
    check(status[3] == 1'b0, "R8", "active bit clear", longint'(status[3]), 0);

    // R10 stopped recovered clock
    meas_run = 1'b0;
    ref_sel = 2'b00;
    wait_valid();
    wait_valid();
    wait_valid();
    check(ratio == '0, "R10", "ratio with stopped clock", longint'(ratio), 0);
    check(status[2:0] == 3'b000, "R10", "code with stopped clock", longint'(status[2:0]), 0);

    finish_run();
  end
endmodule